// File: doc/BRIEF.md
# Table-Driven Stepper Timing Sequencer

This block times the steps of a stepper drive without help from a processor during a motion phase. A free-running step counter advances while the block runs. When the counter reaches the last count of the current step period, a step event is raised and the counter returns to zero. A second, separately configured dead-time compare raises a non-overlap event once inside every step, at a fixed count after the step began. A driver stage uses this event to delay switching a phase on.

Every step reads two small internal tables. The next phase pattern is taken from the pattern table and presented on the pattern output. The next step period is taken from the period table and loaded into the period compare register. This register is only ever loaded at a step boundary, so a rising or falling sequence of table values accelerates or decelerates the motor on its own. The processor fills the tables through a simple write port. At each change of motion phase it loads a descriptor: the pattern start index, the period start index, the run length, the end-of-run mode and the dead-time value. At the end of a run the block raises a sticky phase-done flag. It then either keeps repeating the last entry or wraps to the first entry.

Top module: `step_timing_seq`

## Requirements
- R1: After reset, patOut is 0 and phaseDone, stepEvt and deadEvt are all 0.
- R2: While run is high, stepEvt is high in the last cycle of each step, so consecutive step events are exactly P cycles apart for a current period P. A period value of 0 behaves as 1, giving a step event in every cycle.
- R3: In the cycle after the k-th step event of a run (k counted from 0), patOut holds pattern table entry (pattern start + k) modulo the table depth. patOut changes at no other time.
- R4: After the k-th step event the current period becomes period table entry (period start + k + 1). The first step of a run uses entry (period start). The table index wraps modulo the table depth.
- R5: The current period changes only at a step event or a descriptor load. A write to the period table during a step never alters the length of that step.
- R6: With dead-time value N lower than the current period, deadEvt is high for exactly one cycle per step, in the cycle when the step counter equals N. That cycle is N+1 cycles after the previous step event.
- R7: With a dead-time value equal to or above the current period, deadEvt never goes high during that step.
- R8: phaseDone rises in the cycle after the step event that consumes the last entry of a run (offset length-1; a length of 0 acts as 1). It then stays high until the next descriptor load. With cfgWrap = 0, later steps repeat the last pattern and the last period.
- R9: With cfgWrap = 1, the step after the last entry returns to offset 0 for both the pattern and the period.
- R10: While run is low, the counter and the table offset are frozen and no step or dead-time event occurs. After run returns high, the interrupted step finishes with its remaining count.
- R11: A loadCfg pulse, taken whether run is high or low, clears the counter, the table offset and phaseDone. It loads the period from the new start entry, so the next step event follows P cycles of running, counted from the load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | 1 = counting, 0 = frozen |
| wrEn | input | 1 | Table write strobe |
| wrPeriod | input | 1 | Table select for a write: 1 = period table, 0 = pattern table |
| wrAddr | input | AW | Table write index |
| wrData | input | PER_W | Write data (pattern table keeps the low PAT_W bits) |
| loadCfg | input | 1 | Load the run descriptor and restart the run |
| cfgPatStart | input | AW | Pattern table start index |
| cfgPerStart | input | AW | Period table start index |
| cfgLen | input | AW+1 | Number of entries in the run |
| cfgWrap | input | 1 | End-of-run mode: 1 = wrap to start, 0 = hold last entry |
| cfgDead | input | PER_W | Dead-time compare value |
| stepEvt | output | 1 | Step event, high in the last cycle of a step |
| deadEvt | output | 1 | Non-overlap event inside the step |
| patOut | output | PAT_W | Current phase pattern |
| phaseDone | output | 1 | Sticky end-of-run flag |

## Verification
The hardest situation to reach is a step whose length must not depend on a table write landing in the middle of it. The worst case is a write to the very period entry the step will reload from, on the same clock edge as the reload. The bench sets up a one-entry wrapping run so that every step re-reads a single period entry. It writes a new period into that entry on the edge of a step event. It then checks that the next step still runs the old length and that only the step after it picks up the new value. A frozen step, with run dropped partway through, and a descriptor reload while running are reached by timing the control changes a counted number of cycles after an observed step event.

// File: rtl/step_timing_seq_pkg.sv
package step_timing_seq_pkg;

  // Strobes from the timing control to the table datapath.
  typedef struct packed {
    logic advance;  // step boundary: emit pattern, reload period
    logic reload;   // descriptor load: restart the run
  } seqStrobe_t;

endpackage

// File: rtl/step_timing_seq_ctrl.sv
module step_timing_seq_ctrl
  import step_timing_seq_pkg::*;
#(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             loadCfg,
  input  logic [PER_W-1:0] curPeriod,
  input  logic [PER_W-1:0] deadTime,
  output logic [PER_W-1:0] cnt,
  output logic             stepEvt,
  output logic             deadEvt,
  output seqStrobe_t       strb
);

  logic [PER_W-1:0] lastCnt;
  logic             stepHit;
  logic             deadArmed;

  // A zero period acts as one cycle per step.
  assign lastCnt   = (curPeriod == '0) ? '0 : curPeriod - PER_W'(1);
  assign stepHit   = run && (cnt == lastCnt);
  assign deadArmed = deadTime < curPeriod;

  assign stepEvt = stepHit;
  assign deadEvt = run && deadArmed && (cnt == deadTime);

  always_comb begin
    strb         = '0;
    strb.reload  = loadCfg;
    strb.advance = stepHit && !loadCfg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (loadCfg) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= stepHit ? '0 : cnt + PER_W'(1);
    end
  end

endmodule

// File: rtl/step_timing_seq_data.sv
module step_timing_seq_data
  import step_timing_seq_pkg::*;
#(
  parameter int PAT_W = 4,
  parameter int PER_W = 16,
  parameter int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LEN_W = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic             wrEn,
  input  logic             wrPeriod,
  input  logic [AW-1:0]    wrAddr,
  input  logic [PER_W-1:0] wrData,
  input  logic [AW-1:0]    cfgPatStart,
  input  logic [AW-1:0]    cfgPerStart,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             cfgWrap,
  input  logic [PER_W-1:0] cfgDead,
  output logic [PER_W-1:0] curPeriod,
  output logic [PER_W-1:0] deadTime,
  output logic [PAT_W-1:0] patOut,
  output logic             phaseDone
);

  logic [PAT_W-1:0] patMem [DEPTH];
  logic [PER_W-1:0] perMem [DEPTH];

  logic [AW-1:0]    patBase;
  logic [AW-1:0]    perBase;
  logic [LEN_W-1:0] lenReg;
  logic             wrapReg;
  logic [AW-1:0]    ofs;

  logic [AW-1:0]    patAddr;
  logic [AW-1:0]    perNextAddr;
  logic [LEN_W-1:0] ofsNext;
  logic             lastEntry;

  assign patAddr     = patBase + ofs;
  assign perNextAddr = perBase + ofs + AW'(1);
  assign ofsNext     = {1'b0, ofs} + LEN_W'(1);
  // A zero length counts as a single entry.
  assign lastEntry   = ofsNext >= lenReg;

  // Table write port: one bank per table.
  always_ff @(posedge clk) begin
    if (wrEn && !wrPeriod) patMem[wrAddr] <= wrData[PAT_W-1:0];
    if (wrEn &&  wrPeriod) perMem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      patBase   <= '0;
      perBase   <= '0;
      lenReg    <= '0;
      wrapReg   <= 1'b0;
      deadTime  <= '0;
      ofs       <= '0;
      curPeriod <= '0;
      patOut    <= '0;
      phaseDone <= 1'b0;
    end else if (strb.reload) begin
      patBase   <= cfgPatStart;
      perBase   <= cfgPerStart;
      lenReg    <= cfgLen;
      wrapReg   <= cfgWrap;
      deadTime  <= cfgDead;
      ofs       <= '0;
      curPeriod <= perMem[cfgPerStart];
      phaseDone <= 1'b0;
    end else if (strb.advance) begin
      patOut <= patMem[patAddr];
      if (lastEntry) begin
        phaseDone <= 1'b1;
        if (wrapReg) begin
          ofs       <= '0;
          curPeriod <= perMem[perBase];
        end
      end else begin
        ofs       <= ofsNext[AW-1:0];
        curPeriod <= perMem[perNextAddr];
      end
    end
  end

endmodule

// File: rtl/step_timing_seq.sv
module step_timing_seq
  import step_timing_seq_pkg::*;
#(
  parameter int PAT_W = 4,
  parameter int PER_W = 16,
  parameter int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LEN_W = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             wrEn,
  input  logic             wrPeriod,
  input  logic [AW-1:0]    wrAddr,
  input  logic [PER_W-1:0] wrData,
  input  logic             loadCfg,
  input  logic [AW-1:0]    cfgPatStart,
  input  logic [AW-1:0]    cfgPerStart,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             cfgWrap,
  input  logic [PER_W-1:0] cfgDead,
  output logic             stepEvt,
  output logic             deadEvt,
  output logic [PAT_W-1:0] patOut,
  output logic             phaseDone
);

  seqStrobe_t       strb;
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] curPeriod;
  logic [PER_W-1:0] deadTime;

  step_timing_seq_ctrl #(.PER_W(PER_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .run       (run),
    .loadCfg   (loadCfg),
    .curPeriod (curPeriod),
    .deadTime  (deadTime),
    .cnt       (cnt),
    .stepEvt   (stepEvt),
    .deadEvt   (deadEvt),
    .strb      (strb)
  );

  step_timing_seq_data #(.PAT_W(PAT_W), .PER_W(PER_W), .DEPTH(DEPTH)) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrEn        (wrEn),
    .wrPeriod    (wrPeriod),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .cfgPatStart (cfgPatStart),
    .cfgPerStart (cfgPerStart),
    .cfgLen      (cfgLen),
    .cfgWrap     (cfgWrap),
    .cfgDead     (cfgDead),
    .curPeriod   (curPeriod),
    .deadTime    (deadTime),
    .patOut      (patOut),
    .phaseDone   (phaseDone)
  );

endmodule

// File: rtl/step_timing_seq_chk.sv
module step_timing_seq_chk #(
  parameter int PAT_W = 4,
  parameter int PER_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             run,
  input logic             loadCfg,
  input logic             stepEvt,
  input logic             deadEvt,
  input logic [PAT_W-1:0] patOut,
  input logic             phaseDone,
  input logic [PER_W-1:0] cnt,
  input logic [PER_W-1:0] curPeriod
);

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cnt < curPeriod) || (cnt == '0));

  p_step_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    stepEvt |=> (cnt == '0));

  p_pat_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !stepEvt |=> $stable(patOut));

  p_no_midstep_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!stepEvt && !loadCfg) |=> $stable(curPeriod));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (phaseDone && !loadCfg) |=> phaseDone);

  p_quiet_stopped_r10: assert property (@(posedge clk) disable iff (!rstN)
    !run |-> (!stepEvt && !deadEvt));

  p_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !loadCfg) |=> $stable(cnt));

  p_reload_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    loadCfg |=> (!phaseDone && cnt == '0));

endmodule

bind step_timing_seq step_timing_seq_chk #(.PAT_W(PAT_W), .PER_W(PER_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .run       (run),
  .loadCfg   (loadCfg),
  .stepEvt   (stepEvt),
  .deadEvt   (deadEvt),
  .patOut    (patOut),
  .phaseDone (phaseDone),
  .cnt       (cnt),
  .curPeriod (curPeriod)
);

// File: tb/sim_step_timing_seq.sv
module sim_step_timing_seq;

  localparam int PAT_W = 4;
  localparam int PER_W = 16;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             run = 1'b0;
  logic             wrEn = 1'b0;
  logic             wrPeriod = 1'b0;
  logic [AW-1:0]    wrAddr = '0;
  logic [PER_W-1:0] wrData = '0;
  logic             loadCfg = 1'b0;
  logic [AW-1:0]    cfgPatStart = '0;
  logic [AW-1:0]    cfgPerStart = '0;
  logic [AW:0]      cfgLen = '0;
  logic             cfgWrap = 1'b0;
  logic [PER_W-1:0] cfgDead = '0;
  logic             stepEvt;
  logic             deadEvt;
  logic [PAT_W-1:0] patOut;
  logic             phaseDone;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  step_timing_seq #(.PAT_W(PAT_W), .PER_W(PER_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .run(run), .wrEn(wrEn), .wrPeriod(wrPeriod),
    .wrAddr(wrAddr), .wrData(wrData), .loadCfg(loadCfg),
    .cfgPatStart(cfgPatStart), .cfgPerStart(cfgPerStart), .cfgLen(cfgLen),
    .cfgWrap(cfgWrap), .cfgDead(cfgDead), .stepEvt(stepEvt),
    .deadEvt(deadEvt), .patOut(patOut), .phaseDone(phaseDone)
  );

  function automatic int patVal(int i);
    return (i * 5 + 3) % 16;
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeMem(bit isPer, int addr, int data);
    wrEn = 1'b1; wrPeriod = isPer; wrAddr = AW'(addr); wrData = PER_W'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic loadRun(int pS, int perS, int len, bit wrap, int dead);
    cfgPatStart = AW'(pS); cfgPerStart = AW'(perS); cfgLen = (AW+1)'(len);
    cfgWrap = wrap; cfgDead = PER_W'(dead); loadCfg = 1'b1;
    @(negedge clk);
    loadCfg = 1'b0;
  endtask

  // Counts negedges until stepEvt is seen; records dead-time events on the way.
  task automatic waitPulse(output int gap, output int deadAt, output int deadCnt);
    gap = 0; deadAt = -1; deadCnt = 0;
    while (1) begin
      @(negedge clk);
      gap++;
      if (deadEvt) begin deadCnt++; deadAt = gap; end
      if (stepEvt) break;
      if (gap > 2000) break;
    end
  endtask

  // Samples registered outputs just after the edge that follows a step event.
  task automatic afterStep(output int pat, output int done);
    @(posedge clk); #1;
    pat = int'(patOut); done = int'(phaseDone);
  endtask

  task automatic testReset();
    check("R1 patOut", int'(patOut), 0);
    check("R1 phaseDone", int'(phaseDone), 0);
    check("R1 stepEvt", int'(stepEvt), 0);
    check("R1 deadEvt", int'(deadEvt), 0);
  endtask

  // Accelerating run in hold mode: periods 6,5,4,3, dead time 2.
  task automatic testAccelHold();
    int per[4] = '{6, 5, 4, 3};
    int g, dA, dC, p, d;
    for (int i = 0; i < 4; i++) begin
      writeMem(1'b1, i, per[i]);
      writeMem(1'b0, 4 + i, patVal(4 + i));
    end
    loadRun(4, 0, 4, 1'b0, 2);
    run = 1'b1;
    for (int k = 0; k < 6; k++) begin
      waitPulse(g, dA, dC);
      if (k == 0) begin
        check("R2 first step gap", g, per[0] - 1);
        check("R6 dead in first step", dA, 2);
      end else begin
        check("R4 step gap follows table", g, per[k > 3 ? 3 : k]);
        check("R6 dead offset", dA, 3);
      end
      check("R6 one dead per step", dC, 1);
      afterStep(p, d);
      check("R3 pattern", p, patVal(4 + (k > 3 ? 3 : k)));
      check("R8 phaseDone", d, (k >= 3) ? 1 : 0);
    end
    @(negedge clk);
    run = 1'b0;
  endtask

  // Wrapping run, dead time above every period.
  task automatic testWrap();
    int per[3] = '{4, 7, 5};
    int g, dA, dC, p, d;
    for (int i = 0; i < 3; i++) begin
      writeMem(1'b1, 8 + i, per[i]);
      writeMem(1'b0, i, patVal(i));
    end
    check("R8 done still set before reload", int'(phaseDone), 1);
    loadRun(0, 8, 3, 1'b1, 9);
    check("R11 reload clears phaseDone", int'(phaseDone), 0);
    run = 1'b1;
    for (int k = 0; k < 5; k++) begin
      waitPulse(g, dA, dC);
      check(k >= 3 ? "R9 wrapped gap" : "R4 gap", g, (k == 0) ? per[0] - 1 : per[k % 3]);
      check("R7 no dead event", dC, 0);
      afterStep(p, d);
      check("R9 pattern wraps", p, patVal(k % 3));
    end
    @(negedge clk);
    run = 1'b0;
  endtask

  // Stop partway through a step and resume.
  task automatic testStopResume();
    int g, dA, dC, p, d, quiet;
    writeMem(1'b1, 12, 10);
    writeMem(1'b0, 12, patVal(12));
    loadRun(12, 12, 1, 1'b0, 3);
    run = 1'b1;
    waitPulse(g, dA, dC);
    check("R2 gap 10", g, 9);
    repeat (3) @(negedge clk);
    run = 1'b0;
    p = int'(patOut);
    quiet = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (stepEvt || deadEvt) quiet++;
    end
    check("R10 no events while stopped", quiet, 0);
    check("R10 pattern frozen", int'(patOut), p);
    run = 1'b1;
    waitPulse(g, dA, dC);
    check("R10 remaining count", g, 7);
    check("R10 dead after resume", dA, 1);
    afterStep(p, d);
    @(negedge clk);
    run = 1'b0;
  endtask

  // Zero period gives a step every cycle.
  task automatic testZeroPeriod();
    int g, dA, dC;
    writeMem(1'b1, 13, 0);
    loadRun(12, 13, 1, 1'b0, 5);
    run = 1'b1;
    for (int k = 0; k < 3; k++) begin
      waitPulse(g, dA, dC);
      check("R2 zero period", g, 1);
    end
    run = 1'b0;
    @(negedge clk);
  endtask

  // Period table write on the reload edge, then a reload while running.
  task automatic testMidStepWrite();
    int g, dA, dC;
    writeMem(1'b1, 14, 8);
    loadRun(0, 14, 1, 1'b1, 20);
    run = 1'b1;
    waitPulse(g, dA, dC);
    check("R4 gap 8", g, 7);
    writeMem(1'b1, 14, 3);
    waitPulse(g, dA, dC);
    check("R5 step unaffected by write", g, 7);
    waitPulse(g, dA, dC);
    check("R5 new period next step", g, 3);
    repeat (2) @(negedge clk);
    loadRun(12, 12, 1, 1'b0, 3);
    waitPulse(g, dA, dC);
    check("R11 reload while running", g, 9);
    run = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAccelHold();
    testWrap();
    testStopResume();
    testZeroPeriod();
    testMidStepWrite();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule